// File: doc/BRIEF.md
# Prescaled Match-Compare Interval Timer

This block is a 32-bit up-counting timer used to produce a periodic tick interrupt. The input clock first passes through a programmable prescaler. The prescaler divides it by the prescale limit plus one, and each prescaled tick advances the main counter by one. A match register is compared against the counter. When the counter reaches the match value, a sticky status flag is set, and the flag drives a level interrupt if its enable bit is set. The counter does not stop or reload at the match point. Software schedules each new period by adding the period length to the match value and then clearing the flag.

A small run-control state machine decides what the counting datapath does. It has four states:
- `ST_STOP`: idle, counter frozen.
- `ST_CLEAR`: counter and prescaler held at zero.
- `ST_RUN`: counting.
- `ST_HALT`: frozen because the debug input is active.

The state machine moves to `ST_CLEAR` whenever the clear bit is set, because clear has the highest priority. Otherwise it moves to `ST_STOP` when the enable bit is low. Otherwise it moves to `ST_HALT` when both the halt-on-debug bit and `dbg_active` are high. In every other case it moves to `ST_RUN`. It re-evaluates these conditions on every clock. Control writes therefore take effect one clock after the write edge.

Software reaches the block through a flat register port: one write strobe, a word address, and combinational read data.

Top module: `tmr_interval_top`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: Control bit 0 (offset 0x00) enables counting. The first increment lands on the second clock edge after the write edge. When bit 0 is cleared, the counter value freezes.
- R3: With prescale limit P (offset 0x08), the counter at offset 0x04 advances once every P+1 clocks. N clock edges after enabling from a cleared state, it reads floor((N-1)/(P+1)).
- R4: Control bit 1 forces the counter and prescaler to zero and overrides bit 0. The counter reads zero two edges after the write and stays zero while the bit is held.
- R5: While control bit 2 and `dbg_active` are both high, counting halts. When bit 2 is low, `dbg_active` has no effect.
- R6: Status bit 0 (offset 0x18) is set on the prescaled tick at which the counter becomes equal to the match value (offset 0x10). The counter keeps incrementing past that point.
- R7: Writing 1 to status bit 0 clears the flag. Writing 0 leaves the flag unchanged.
- R8: `irq` is high exactly when status bit 0 is set and match-control bit 0 (offset 0x0C) is set.
- R9: The counter is read-only, and writes to offset 0x04 are ignored.
- R10: The capture-control register (offset 0x14) reads back what was written and has no effect on counting.
- R11: Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_active | input | 1 | Debugger-active indication, used for the halt-on-debug bit |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Combinational read data |
| irq | output | 1 | Level interrupt: match flag AND its enable |

## Verification
Some internal faults show up at the counter port. A wrong run-control state or prescaler value produces a counter read that is off by one at an exact edge count after enabling, so the bench samples at the cycle where the count must step. A stuck or late match flag appears on `irq` and the status register on the same edge the counter reaches the match value, so the bench checks the edge just before that one and the match edge itself. A clear that misses the prescaler appears only one full prescale period after restarting, so the restart is checked at both sides of the first tick.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int BUS_W = 32;

    // Register byte offsets
    localparam int OFF_CTRL  = 'h00;
    localparam int OFF_COUNT = 'h04;
    localparam int OFF_PRE   = 'h08;
    localparam int OFF_MCTL  = 'h0C;
    localparam int OFF_MATCH = 'h10;
    localparam int OFF_CAP   = 'h14;
    localparam int OFF_STAT  = 'h18;

    // Control bit positions
    localparam int CTL_RUN_BIT = 0;
    localparam int CTL_CLR_BIT = 1;
    localparam int CTL_DBG_BIT = 2;
    localparam int CTL_W       = 3;

    typedef enum logic [1:0] {
        ST_STOP  = 2'd0,
        ST_CLEAR = 2'd1,
        ST_RUN   = 2'd2,
        ST_HALT  = 2'd3
    } run_state_t;
endpackage

// File: rtl/tmr_run_fsm.sv
module tmr_run_fsm
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_run,
    input  logic       ctl_clr,
    input  logic       ctl_dbg,
    input  logic       dbg_active,
    output run_state_t state,
    output logic       active,
    output logic       clear
);
    run_state_t state_nxt;

    // Next-state selection: clear > stop > debug halt > run
    always_comb begin
        if (ctl_clr)
            state_nxt = ST_CLEAR;
        else if (!ctl_run)
            state_nxt = ST_STOP;
        else if (ctl_dbg && dbg_active)
            state_nxt = ST_HALT;
        else
            state_nxt = ST_RUN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_STOP;
        else
            state <= state_nxt;
    end

    always_comb begin
        active = 1'b0;
        clear  = 1'b0;
        unique case (state)
            ST_STOP:  ;
            ST_CLEAR: clear  = 1'b1;
            ST_RUN:   active = 1'b1;
            ST_HALT:  ;
            default:  ;
        endcase
    end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PRE_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             active,
    input  logic [PRE_W-1:0] limit,
    output logic             tick
);
    logic [PRE_W-1:0] pre_q;

    // ">=" so that lowering the limit below the current value wraps at once
    assign tick = active && (pre_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pre_q <= '0;
        else if (clear)
            pre_q <= '0;
        else if (active)
            pre_q <= tick ? '0 : pre_q + 1'b1;
    end
endmodule

// File: rtl/tmr_match_unit.sv
module tmr_match_unit #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] match_val,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             flag
);
    logic [CNT_W-1:0] cnt_nxt;
    logic             hit;

    assign cnt_nxt = cnt + 1'b1;   // wraps from all-ones to zero
    assign hit     = tick && (cnt_nxt == match_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (tick)
            cnt <= cnt_nxt;
    end

    // A new hit wins over a simultaneous clear request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (hit)
            flag <= 1'b1;
        else if (flag_clr)
            flag <= 1'b0;
    end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int CNT_W  = 32,
    parameter int PRE_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              flag,
    output logic [BUS_W-1:0]  rdata,
    output logic              ctl_run,
    output logic              ctl_clr,
    output logic              ctl_dbg,
    output logic [PRE_W-1:0]  pre_lim,
    output logic              irq_en,
    output logic [CNT_W-1:0]  match_val,
    output logic              flag_clr
);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFF_COUNT);
    localparam logic [ADDR_W-1:0] A_PRE   = ADDR_W'(OFF_PRE);
    localparam logic [ADDR_W-1:0] A_MCTL  = ADDR_W'(OFF_MCTL);
    localparam logic [ADDR_W-1:0] A_MATCH = ADDR_W'(OFF_MATCH);
    localparam logic [ADDR_W-1:0] A_CAP   = ADDR_W'(OFF_CAP);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STAT);

    logic [CTL_W-1:0] ctrl_q;
    logic [BUS_W-1:0] cap_q;

    assign ctl_run  = ctrl_q[CTL_RUN_BIT];
    assign ctl_clr  = ctrl_q[CTL_CLR_BIT];
    assign ctl_dbg  = ctrl_q[CTL_DBG_BIT];
    assign flag_clr = wr && (addr == A_STAT) && wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            pre_lim   <= '0;
            irq_en    <= 1'b0;
            match_val <= '0;
            cap_q     <= '0;
        end else if (wr) begin
            case (addr)
                A_CTRL:  ctrl_q    <= wdata[CTL_W-1:0];
                A_PRE:   pre_lim   <= wdata[PRE_W-1:0];
                A_MCTL:  irq_en    <= wdata[0];
                A_MATCH: match_val <= wdata[CNT_W-1:0];
                A_CAP:   cap_q     <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:  rdata = BUS_W'(ctrl_q);
            A_COUNT: rdata = BUS_W'(cnt);
            A_PRE:   rdata = BUS_W'(pre_lim);
            A_MCTL:  rdata = BUS_W'(irq_en);
            A_MATCH: rdata = BUS_W'(match_val);
            A_CAP:   rdata = cap_q;
            A_STAT:  rdata = BUS_W'(flag);
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_interval_top.sv
module tmr_interval_top
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int CNT_W  = 32,
    parameter int PRE_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_active,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    run_state_t       run_state;
    logic             run_active;
    logic             run_clear;
    logic             pre_tick;
    logic             ctl_run;
    logic             ctl_clr;
    logic             ctl_dbg;
    logic [PRE_W-1:0] pre_lim;
    logic             irq_en;
    logic [CNT_W-1:0] match_val;
    logic             flag_clr;
    logic [CNT_W-1:0] cnt_val;
    logic             match_flag;

    tmr_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .cnt       (cnt_val),
        .flag      (match_flag),
        .rdata     (bus_rdata),
        .ctl_run   (ctl_run),
        .ctl_clr   (ctl_clr),
        .ctl_dbg   (ctl_dbg),
        .pre_lim   (pre_lim),
        .irq_en    (irq_en),
        .match_val (match_val),
        .flag_clr  (flag_clr)
    );

    tmr_run_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_run    (ctl_run),
        .ctl_clr    (ctl_clr),
        .ctl_dbg    (ctl_dbg),
        .dbg_active (dbg_active),
        .state      (run_state),
        .active     (run_active),
        .clear      (run_clear)
    );

    tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (run_clear),
        .active (run_active),
        .limit  (pre_lim),
        .tick   (pre_tick)
    );

    tmr_match_unit #(.CNT_W(CNT_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (run_clear),
        .tick      (pre_tick),
        .match_val (match_val),
        .flag_clr  (flag_clr),
        .cnt       (cnt_val),
        .flag      (match_flag)
    );

    assign irq = match_flag & irq_en;
endmodule

// File: rtl/tmr_interval_sva.sv
module tmr_interval_sva
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input run_state_t       state,
    input logic             tick,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] match_val,
    input logic             flag,
    input logic             irq_en,
    input logic             irq
);
    AST_CLEAR_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLEAR) |=> (cnt == '0)); // R4

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP || state == ST_HALT) |=> $stable(cnt)); // R5

    AST_NO_TICK_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !tick) |=> $stable(cnt)); // R3

    AST_TICK_STEPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == CNT_W'($past(cnt) + 1'b1))); // R2

    AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (CNT_W'(cnt + 1'b1) == match_val)) |=> flag); // R6

    AST_FLAG_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(tick)); // R6

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq); // R8
endmodule

bind tmr_interval_top tmr_interval_sva #(.CNT_W(CNT_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (run_state),
    .tick      (pre_tick),
    .cnt       (cnt_val),
    .match_val (match_val),
    .flag      (match_flag),
    .irq_en    (irq_en),
    .irq       (irq)
);

// File: tb/tmr_interval_top_tb.sv
module tmr_interval_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_active = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [4:0] A_CTRL = 5'h00, A_CNT = 5'h04, A_PRE = 5'h08,
                           A_MCTL = 5'h0C, A_MAT = 5'h10, A_CAP = 5'h14,
                           A_STAT = 5'h18;
    localparam logic [31:0] C_RUN = 32'h1, C_CLR = 32'h2, C_DBG = 32'h4;

    always #5 clk = ~clk;

    tmr_interval_top u_dut (
        .clk(clk), .rst_n(rst_n), .dbg_active(dbg_active), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Returns at the falling edge following the write edge
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic restart(input logic [31:0] pre);
        wr(A_PRE, pre);
        wr(A_CTRL, C_CLR);
        wr(A_CTRL, C_RUN);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(A_CTRL, v); chk("R1 ctrl", v, 0);
        rd(A_CNT, v);  chk("R1 count", v, 0);
        rd(A_PRE, v);  chk("R1 prescale", v, 0);
        rd(A_MCTL, v); chk("R1 match ctl", v, 0);
        rd(A_MAT, v);  chk("R1 match", v, 0);
        rd(A_CAP, v);  chk("R1 capture", v, 0);
        rd(A_STAT, v); chk("R1 status", v, 0);
        chk("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_count;
        logic [31:0] v1, v2;
        restart(0);
        step(10);
        rd(A_CNT, v1); chk("R2 count after enable", v1, 9);
        wr(A_CTRL, 0);
        step(3);
        rd(A_CNT, v1);
        step(5);
        rd(A_CNT, v2); chk("R2 frozen when disabled", v2, v1);
    endtask

    task automatic t_prescale;
        logic [31:0] v;
        restart(12);
        step(65);
        rd(A_CNT, v); chk("R3 before 5th tick", v, 4);
        step(1);
        rd(A_CNT, v); chk("R3 at 5th tick", v, 5);
    endtask

    task automatic t_clear;
        logic [31:0] v;
        wr(A_CTRL, C_RUN | C_CLR);
        step(2);
        rd(A_CNT, v); chk("R4 zero after clear", v, 0);
        step(5);
        rd(A_CNT, v); chk("R4 held at zero", v, 0);
        wr(A_CTRL, C_RUN);
        step(13);
        rd(A_CNT, v); chk("R4 prescaler cleared (before tick)", v, 0);
        step(1);
        rd(A_CNT, v); chk("R4 prescaler cleared (first tick)", v, 1);
    endtask

    task automatic t_debug;
        logic [31:0] v, w;
        wr(A_PRE, 0);
        wr(A_CTRL, C_CLR);
        dbg_active = 1'b1;
        wr(A_CTRL, C_RUN | C_DBG);
        step(10);
        rd(A_CNT, v); chk("R5 halted by debug", v, 0);
        dbg_active = 1'b0;
        step(10);
        rd(A_CNT, v); chk("R5 resumes after debug", v, 9);
        dbg_active = 1'b1;
        step(2);
        rd(A_CNT, v);
        step(6);
        rd(A_CNT, w); chk("R5 holds during debug", w, v);
        wr(A_CTRL, C_RUN);
        step(10);
        rd(A_CNT, w); chk("R5 debug ignored when bit clear", w, v + 9);
        dbg_active = 1'b0;
    endtask

    task automatic t_match;
        logic [31:0] v, c;
        wr(A_MAT, 5);
        wr(A_MCTL, 1);
        restart(0);
        step(5);
        rd(A_STAT, v); chk("R6 flag clear before match", v, 0);
        chk("R8 irq low before match", {31'b0, irq}, 0);
        step(1);
        rd(A_CNT, v);  chk("R6 counter equals match", v, 5);
        rd(A_STAT, v); chk("R6 flag set at match", v, 1);
        chk("R8 irq high at match", {31'b0, irq}, 1);
        step(3);
        rd(A_CNT, v); chk("R6 counter runs past match", v, 8);
        // R7 write zero keeps flag
        wr(A_STAT, 0);
        rd(A_STAT, v); chk("R7 write 0 keeps flag", v, 1);
        // R8 masking
        wr(A_MCTL, 0);
        chk("R8 irq masked", {31'b0, irq}, 0);
        wr(A_MCTL, 1);
        chk("R8 irq unmasked", {31'b0, irq}, 1);
        wr(A_STAT, 1);
        rd(A_STAT, v); chk("R7 write 1 clears flag", v, 0);
        chk("R8 irq low after clear", {31'b0, irq}, 0);
        // schedule the next period ahead of the free-running counter
        rd(A_CNT, c);
        wr(A_MAT, c + 8);
        step(5);
        rd(A_STAT, v); chk("R6 rescheduled, not yet", v, 0);
        step(1);
        rd(A_STAT, v); chk("R6 rescheduled match", v, 1);
        wr(A_STAT, 1);
    endtask

    task automatic t_ro_cap;
        logic [31:0] v, w;
        wr(A_CTRL, 0);
        step(3);
        rd(A_CNT, v);
        wr(A_CNT, 32'h0000_1234);
        rd(A_CNT, w); chk("R9 counter write ignored", w, v);
        wr(A_CAP, 32'hDEAD_BEEF);
        rd(A_CAP, w); chk("R10 capture readback", w, 32'hDEAD_BEEF);
        rd(A_CNT, w); chk("R10 capture leaves counter", w, v);
        wr(A_CAP, 0);
        restart(0);
        step(4);
        rd(A_CNT, w); chk("R10 counting unaffected", w, 3);
        rd(5'h1C, w); chk("R11 unmapped 0x1C", w, 0);
        rd(5'h02, w); chk("R11 unmapped 0x02", w, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        step(1);
        t_count;
        t_prescale;
        t_clear;
        t_debug;
        t_match;
        t_ro_cap;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule